// File: doc/BRIEF.md
# Trapping Signed Add/Subtract Unit

This unit performs the integer add and subtract operations of a 64-bit processor's execute stage, in both a full-width form and a 32-bit form whose result is sign-extended into the 64-bit destination. The second operand is either a register value or a sign-extended 16-bit immediate. Each operation is either trapping or non-trapping.

For trapping operations, the unit checks the result for two's-complement overflow at the width of the operation. When overflow occurs, the register write is cancelled. In its place the unit raises an overflow exception request, and that request carries the program counter of the offending instruction. Non-trapping operations use the same datapath and always write their wrapped result.

The unit accepts one operation per cycle. Both the writeback and the exception request come out of one register stage, in the cycle after the operation is presented. The unit does not contain the register file, the pipeline control or the exception vectoring.

Top module: `trap_addsub_unit`

## Requirements
- R1: `op_sel` encoding is as follows. Bit 3 selects subtract (1) or add (0). Bit 2 selects 64-bit (1) or 32-bit (0) width. Bit 1 selects the sign-extended immediate (1) or `src_b` (0) as the second operand. Bit 0 marks a non-trapping operation. An operation presented with `in_valid` high at a rising edge appears on the outputs right after that edge.
- R2: A 64-bit operation computes `src_a + b` or `src_a - b` over all 64 bits, modulo 2^64, and writes the result unchanged.
- R3: A 32-bit operation uses only bits 31:0 of each operand. Its 32-bit result is sign-extended to 64 bits on `wb_data`.
- R4: `imm` is sign-extended to the operation width before use. Immediate forms write the register named by `rt_idx`. Register forms write the register named by `rd_idx`.
- R5: An addition overflows when both operands have the same sign bit at the operation width (bit 31 or bit 63) and the result's sign bit differs from it.
- R6: A subtraction a - b overflows when the sign bits of a and b differ and the result's sign bit differs from that of a.
- R7: When a trapping operation overflows, `wb_en` stays low. `exc_valid` pulses for that one cycle with `exc_code` equal to `OVF_CODE` (default 12), and `exc_pc` holds the `pc` of that operation.
- R8: A non-trapping operation never raises `exc_valid`. It always writes its wrapped result.
- R9: A write to register index 0 is discarded (`wb_en` low). An overflow trap on such an operation is still raised.
- R10: Reset drives all outputs to zero. A cycle without `in_valid` leaves `wb_en` and `exc_valid` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 4 | Operation select: subtract, wide, immediate, non-trapping |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second register operand |
| imm | input | 16 | Immediate operand |
| rd_idx | input | 5 | Destination index for register forms |
| rt_idx | input | 5 | Destination index for immediate forms |
| pc | input | 64 | Program counter of the operation |
| wb_en | output | 1 | Register write enable |
| wb_idx | output | 5 | Register write index |
| wb_data | output | 64 | Register write data |
| exc_valid | output | 1 | Overflow exception request pulse |
| exc_code | output | 5 | Exception cause code |
| exc_pc | output | 64 | PC of the trapping operation |

## Verification
The assertions assume that `op_sel`, `pc` and the two index fields are stable and known whenever `in_valid` is high. They also assume that the output stage sees each operation exactly once. The stimulus meets these assumptions by changing every input only on the falling clock edge, and by holding `in_valid` for exactly one cycle per operation.

Directed operands sit on the signed limits at both widths, such as the largest positive value plus one and the most negative value minus one. Random operands are drawn from a pool weighted toward those limits, so that trapping and non-trapping overflow cases both occur, including on back-to-back cycles.

// File: rtl/taddsub_pkg.sv
package taddsub_pkg;
   typedef struct packed {
      logic is_sub;
      logic is_wide;
      logic use_imm;
      logic no_trap;
   } op_sel_t;

   localparam int unsigned OP_SEL_W = $bits(op_sel_t);
endpackage

// File: rtl/taddsub_operand_mux.sv
module taddsub_operand_mux
   import taddsub_pkg::*;
#(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned IMM_W = 16
) (
   input  op_sel_t          op,
   input  logic [XLEN-1:0]  src_a,
   input  logic [XLEN-1:0]  src_b,
   input  logic [IMM_W-1:0] imm,
   output logic [XLEN-1:0]  opa,
   output logic [XLEN-1:0]  opb
);
   localparam int unsigned EXT_W = XLEN - IMM_W;

   logic [XLEN-1:0] imm_sext;

   assign imm_sext = {{EXT_W{imm[IMM_W-1]}}, imm};
   assign opa      = src_a;
   assign opb      = op.use_imm ? imm_sext : src_b;
endmodule

// File: rtl/taddsub_ovf_detect.sv
module taddsub_ovf_detect (
   input  logic is_sub,
   input  logic a_msb,
   input  logic b_msb,
   input  logic r_msb,
   output logic ovf
);
   logic signs_differ;
   logic result_flipped;

   assign signs_differ   = a_msb ^ b_msb;
   assign result_flipped = a_msb ^ r_msb;
   assign ovf = (is_sub ? signs_differ : ~signs_differ) & result_flipped;
endmodule

// File: rtl/taddsub_core.sv
module taddsub_core #(
   parameter int unsigned XLEN         = 64,
   parameter int unsigned HALF         = 32,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic            is_sub,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   output logic [XLEN-1:0] sum_full,
   output logic [HALF-1:0] sum_half,
   output logic            ovf_full,
   output logic            ovf_half
);
   logic [XLEN-1:0] b_eff;

   assign b_eff    = is_sub ? ~opb : opb;
   assign sum_full = opa + b_eff + XLEN'(is_sub);

   generate
      if (SHARED_ADDER) begin : g_shared
         assign sum_half = sum_full[HALF-1:0];
      end else begin : g_split
         logic [HALF-1:0] b_eff_half;
         assign b_eff_half = b_eff[HALF-1:0];
         assign sum_half   = opa[HALF-1:0] + b_eff_half + HALF'(is_sub);
      end
   endgenerate

   taddsub_ovf_detect u_ovf_full (
      .is_sub (is_sub),
      .a_msb  (opa[XLEN-1]),
      .b_msb  (opb[XLEN-1]),
      .r_msb  (sum_full[XLEN-1]),
      .ovf    (ovf_full)
   );

   taddsub_ovf_detect u_ovf_half (
      .is_sub (is_sub),
      .a_msb  (opa[HALF-1]),
      .b_msb  (opb[HALF-1]),
      .r_msb  (sum_half[HALF-1]),
      .ovf    (ovf_half)
   );
endmodule

// File: rtl/taddsub_dest_sel.sv
module taddsub_dest_sel
   import taddsub_pkg::*;
#(
   parameter int unsigned XLEN      = 64,
   parameter int unsigned HALF      = 32,
   parameter int unsigned REG_IDX_W = 5
) (
   input  logic                 valid,
   input  op_sel_t              op,
   input  logic [XLEN-1:0]      sum_full,
   input  logic [HALF-1:0]      sum_half,
   input  logic                 ovf_full,
   input  logic                 ovf_half,
   input  logic [REG_IDX_W-1:0] rd_idx,
   input  logic [REG_IDX_W-1:0] rt_idx,
   output logic                 wr_en,
   output logic [REG_IDX_W-1:0] wr_idx,
   output logic [XLEN-1:0]      wr_data,
   output logic                 trap
);
   localparam int unsigned EXT_W = XLEN - HALF;

   logic ovf_sel;

   always_comb begin
      ovf_sel = op.is_wide ? ovf_full : ovf_half;
      trap    = valid & ~op.no_trap & ovf_sel;
      wr_idx  = op.use_imm ? rt_idx : rd_idx;
      wr_data = op.is_wide ? sum_full
                           : {{EXT_W{sum_half[HALF-1]}}, sum_half};
      wr_en   = valid & ~trap & (wr_idx != '0);
   end
endmodule

// File: rtl/trap_addsub_unit.sv
module trap_addsub_unit
   import taddsub_pkg::*;
#(
   parameter int unsigned XLEN         = 64,
   parameter int unsigned HALF         = 32,
   parameter int unsigned IMM_W        = 16,
   parameter int unsigned REG_IDX_W    = 5,
   parameter int unsigned PC_W         = 64,
   parameter int unsigned EXC_W        = 5,
   parameter int unsigned OVF_CODE     = 12,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [3:0]           op_sel,
   input  logic [XLEN-1:0]      src_a,
   input  logic [XLEN-1:0]      src_b,
   input  logic [IMM_W-1:0]     imm,
   input  logic [REG_IDX_W-1:0] rd_idx,
   input  logic [REG_IDX_W-1:0] rt_idx,
   input  logic [PC_W-1:0]      pc,
   output logic                 wb_en,
   output logic [REG_IDX_W-1:0] wb_idx,
   output logic [XLEN-1:0]      wb_data,
   output logic                 exc_valid,
   output logic [EXC_W-1:0]     exc_code,
   output logic [PC_W-1:0]      exc_pc
);
   localparam logic [EXC_W-1:0] OVF_CODE_V = EXC_W'(OVF_CODE);

   generate
      if (HALF == 0 || HALF >= XLEN) begin : g_bad_half
         $error("trap_addsub_unit: HALF must lie strictly between 0 and XLEN");
      end
      if (IMM_W == 0 || IMM_W > HALF) begin : g_bad_imm
         $error("trap_addsub_unit: IMM_W must be 1..HALF");
      end
      if (OVF_CODE >= (1 << EXC_W)) begin : g_bad_code
         $error("trap_addsub_unit: OVF_CODE does not fit EXC_W bits");
      end
      if (OP_SEL_W != 4) begin : g_bad_op
         $error("trap_addsub_unit: op_sel_t width mismatch");
      end
   endgenerate

   op_sel_t                op;
   logic [XLEN-1:0]        opa;
   logic [XLEN-1:0]        opb;
   logic [XLEN-1:0]        sum_full;
   logic [HALF-1:0]        sum_half;
   logic                   ovf_full;
   logic                   ovf_half;
   logic                   nx_wr_en;
   logic [REG_IDX_W-1:0]   nx_wr_idx;
   logic [XLEN-1:0]        nx_wr_data;
   logic                   nx_trap;

   assign op = op_sel_t'(op_sel);

   taddsub_operand_mux #(
      .XLEN  (XLEN),
      .IMM_W (IMM_W)
   ) u_opmux (
      .op    (op),
      .src_a (src_a),
      .src_b (src_b),
      .imm   (imm),
      .opa   (opa),
      .opb   (opb)
   );

   taddsub_core #(
      .XLEN         (XLEN),
      .HALF         (HALF),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_core (
      .is_sub   (op.is_sub),
      .opa      (opa),
      .opb      (opb),
      .sum_full (sum_full),
      .sum_half (sum_half),
      .ovf_full (ovf_full),
      .ovf_half (ovf_half)
   );

   taddsub_dest_sel #(
      .XLEN      (XLEN),
      .HALF      (HALF),
      .REG_IDX_W (REG_IDX_W)
   ) u_dest (
      .valid    (in_valid),
      .op       (op),
      .sum_full (sum_full),
      .sum_half (sum_half),
      .ovf_full (ovf_full),
      .ovf_half (ovf_half),
      .rd_idx   (rd_idx),
      .rt_idx   (rt_idx),
      .wr_en    (nx_wr_en),
      .wr_idx   (nx_wr_idx),
      .wr_data  (nx_wr_data),
      .trap     (nx_trap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_en     <= 1'b0;
         wb_idx    <= '0;
         wb_data   <= '0;
         exc_valid <= 1'b0;
         exc_code  <= '0;
         exc_pc    <= '0;
      end else begin
         wb_en     <= nx_wr_en;
         exc_valid <= nx_trap;
         if (in_valid) begin
            wb_idx  <= nx_wr_idx;
            wb_data <= nx_wr_data;
         end
         if (nx_trap) begin
            exc_code <= OVF_CODE_V;
            exc_pc   <= pc;
         end
      end
   end
endmodule

// File: rtl/trap_addsub_unit_chk.sv
module trap_addsub_unit_chk #(
   parameter int unsigned XLEN      = 64,
   parameter int unsigned HALF      = 32,
   parameter int unsigned REG_IDX_W = 5,
   parameter int unsigned PC_W      = 64,
   parameter int unsigned EXC_W     = 5,
   parameter int unsigned OVF_CODE  = 12
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [3:0]           op_sel,
   input logic [REG_IDX_W-1:0] rd_idx,
   input logic [REG_IDX_W-1:0] rt_idx,
   input logic [PC_W-1:0]      pc,
   input logic                 wb_en,
   input logic [REG_IDX_W-1:0] wb_idx,
   input logic [XLEN-1:0]      wb_data,
   input logic                 exc_valid,
   input logic [EXC_W-1:0]     exc_code,
   input logic [PC_W-1:0]      exc_pc
);
   localparam int unsigned EXT_W = XLEN - HALF;

   p_trap_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> !wb_en);

   p_trap_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (exc_code == EXC_W'(OVF_CODE)));

   p_trap_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (exc_pc == $past(pc)));

   p_no_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && $past(op_sel[0])) |-> !exc_valid);

   p_zero_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_idx != '0));

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> (!wb_en && !exc_valid));

   p_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && !$past(op_sel[2]))
         |-> (wb_data[XLEN-1:HALF] == {EXT_W{wb_data[HALF-1]}}));

   p_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_idx == ($past(op_sel[1]) ? $past(rt_idx) : $past(rd_idx))));
endmodule

bind trap_addsub_unit trap_addsub_unit_chk #(
   .XLEN      (XLEN),
   .HALF      (HALF),
   .REG_IDX_W (REG_IDX_W),
   .PC_W      (PC_W),
   .EXC_W     (EXC_W),
   .OVF_CODE  (OVF_CODE)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_sel    (op_sel),
   .rd_idx    (rd_idx),
   .rt_idx    (rt_idx),
   .pc        (pc),
   .wb_en     (wb_en),
   .wb_idx    (wb_idx),
   .wb_data   (wb_data),
   .exc_valid (exc_valid),
   .exc_code  (exc_code),
   .exc_pc    (exc_pc)
);

// File: tb/trap_addsub_unit_tb_top.sv
`timescale 1ns/1ps
module trap_addsub_unit_tb_top;
   // op_sel bits: [3] subtract, [2] 64-bit, [1] immediate, [0] non-trapping
   localparam logic [3:0] ADD32   = 4'b0000, ADDU32  = 4'b0001;
   localparam logic [3:0] ADDI32  = 4'b0010, ADDIU32 = 4'b0011;
   localparam logic [3:0] ADD64   = 4'b0100, ADDU64  = 4'b0101;
   localparam logic [3:0] ADDI64  = 4'b0110;
   localparam logic [3:0] SUB32   = 4'b1000, SUBU32  = 4'b1001;
   localparam logic [3:0] SUB64   = 4'b1100, SUBU64  = 4'b1101;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  op_sel = '0;
   logic [63:0] src_a = '0, src_b = '0, pc = '0;
   logic [15:0] imm = '0;
   logic [4:0]  rd_idx = '0, rt_idx = '0;
   logic        wb_en, exc_valid;
   logic [4:0]  wb_idx, exc_code;
   logic [63:0] wb_data, exc_pc;

   int tests_run = 0;
   int tests_failed = 0;
   int cycle_cnt = 0;
   bit mon_en = 1'b0;

   typedef struct {
      int          cyc;
      string       tag;
      logic        wb_en;
      logic [4:0]  wb_idx;
      logic [63:0] wb_data;
      logic        exc;
      logic [63:0] exc_pc;
   } exp_t;

   exp_t sb_q[$];

   always #4 clk = ~clk;
   always @(posedge clk) cycle_cnt <= cycle_cnt + 1;

   trap_addsub_unit dut_i (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .op_sel (op_sel),
      .src_a (src_a), .src_b (src_b), .imm (imm), .rd_idx (rd_idx),
      .rt_idx (rt_idx), .pc (pc), .wb_en (wb_en), .wb_idx (wb_idx),
      .wb_data (wb_data), .exc_valid (exc_valid), .exc_code (exc_code),
      .exc_pc (exc_pc)
   );

   // Reference model: overflow from widened signed arithmetic
   function automatic exp_t model(logic [3:0] op, logic [63:0] a, logic [63:0] b,
                                  logic [15:0] im, logic [4:0] rd, logic [4:0] rt,
                                  logic [63:0] p, string tag);
      exp_t e;
      logic [63:0] bo;
      logic [64:0] s65;
      logic [32:0] s33;
      logic ovf, trap;
      logic [4:0] dst;
      bo  = op[1] ? {{48{im[15]}}, im} : b;
      s65 = op[3] ? ({a[63], a} - {bo[63], bo}) : ({a[63], a} + {bo[63], bo});
      s33 = op[3] ? ({a[31], a[31:0]} - {bo[31], bo[31:0]})
                  : ({a[31], a[31:0]} + {bo[31], bo[31:0]});
      ovf  = op[2] ? (s65[64] != s65[63]) : (s33[32] != s33[31]);
      trap = ovf && !op[0];
      dst  = op[1] ? rt : rd;
      e.cyc     = 0;
      e.tag     = tag;
      e.exc     = trap;
      e.exc_pc  = p;
      e.wb_en   = !trap && (dst != 5'd0);
      e.wb_idx  = dst;
      e.wb_data = op[2] ? s65[63:0] : {{32{s33[31]}}, s33[31:0]};
      return e;
   endfunction

   task automatic issue(logic [3:0] op, logic [63:0] a, logic [63:0] b,
                        logic [15:0] im, logic [4:0] rd, logic [4:0] rt,
                        logic [63:0] p, string tag);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1; op_sel = op; src_a = a; src_b = b; imm = im;
      rd_idx = rd; rt_idx = rt; pc = p;
      e = model(op, a, b, im, rd, rt, p, tag);
      e.cyc = cycle_cnt;
      sb_q.push_back(e);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         src_a = 64'hDEAD_BEEF_0BAD_F00D;
      end
   endtask

   // Monitor: pops the item issued one cycle earlier, else expects idle outputs
   always @(negedge clk) begin
      if (mon_en) begin
         if (sb_q.size() > 0 && sb_q[0].cyc == cycle_cnt - 1) begin
            exp_t e;
            bit ok;
            e = sb_q.pop_front();
            ok = (wb_en == e.wb_en) && (exc_valid == e.exc) &&
                 (!e.wb_en || (wb_idx == e.wb_idx && wb_data == e.wb_data)) &&
                 (!e.exc || (exc_pc == e.exc_pc && exc_code == 5'd12));
            tests_run++;
            if (!ok) begin
               tests_failed++;
               $display("FAIL %s: act wb_en=%0b idx=%0d data=%h exc=%0b code=%0d pc=%h | exp wb_en=%0b idx=%0d data=%h exc=%0b code=12 pc=%h",
                        e.tag, wb_en, wb_idx, wb_data, exc_valid, exc_code, exc_pc,
                        e.wb_en, e.wb_idx, e.wb_data, e.exc, e.exc_pc);
            end
         end else begin
            tests_run++;
            if (wb_en || exc_valid) begin
               tests_failed++;
               $display("FAIL R10 idle: act wb_en=%0b exc=%0b exp wb_en=0 exc=0",
                        wb_en, exc_valid);
            end
         end
      end
   end

   function automatic logic [63:0] pick();
      case ($urandom_range(0, 7))
         0: return 64'h7FFF_FFFF_FFFF_FFFF;
         1: return 64'h8000_0000_0000_0000;
         2: return 64'h0000_0000_7FFF_FFFF;
         3: return 64'hFFFF_FFFF_8000_0000;
         4: return 64'hFFFF_FFFF_FFFF_FFFF;
         default: return {$urandom(), $urandom()};
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: act hung exp done");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      tests_run++;
      if (wb_en || exc_valid || wb_idx != 0 || wb_data != 0 || exc_code != 0 || exc_pc != 0) begin
         tests_failed++;
         $display("FAIL R10 reset: act wb_en=%0b data=%h exc=%0b pc=%h exp all zero",
                  wb_en, wb_data, exc_valid, exc_pc);
      end
      rst_n = 1'b1;
      mon_en = 1'b1;
      idle(2);

      issue(ADD64, 64'h0123_4567_89AB_CDEF, 64'h1111_1111_1111_1111, 16'h0, 5'd3, 5'd4, 64'h1000, "R2 add64");
      issue(SUB64, 64'h5, 64'h9, 16'h0, 5'd7, 5'd1, 64'h1004, "R2 sub64 negative");
      issue(ADD64, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 16'h0, 5'd2, 5'd1, 64'h1008, "R5 add64 max+0");
      issue(ADD64, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 16'h0, 5'd2, 5'd1, 64'h100C, "R5 R7 add64 max+1 trap");
      issue(ADD64, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0, 5'd2, 5'd1, 64'h1010, "R5 R7 add64 min-1 trap");
      issue(SUB64, 64'h0, 64'h8000_0000_0000_0000, 16'h0, 5'd5, 5'd1, 64'h1014, "R6 sub64 0-min trap");
      issue(SUB64, 64'h8000_0000_0000_0000, 64'h1, 16'h0, 5'd5, 5'd1, 64'h1018, "R6 sub64 min-1 trap");
      issue(ADDU64, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 16'h0, 5'd6, 5'd1, 64'h101C, "R8 addu64 wraps");
      issue(SUBU64, 64'h8000_0000_0000_0000, 64'h1, 16'h0, 5'd6, 5'd1, 64'h1020, "R8 subu64 wraps");
      issue(ADD32, 64'hAAAA_0000_0000_0005, 64'h5555_0000_FFFF_FFF0, 16'h0, 5'd8, 5'd1, 64'h1024, "R3 add32 high bits ignored");
      issue(ADD32, 64'h0000_0000_7FFF_FFFF, 64'h1, 16'h0, 5'd8, 5'd1, 64'h1028, "R3 R5 add32 max+1 trap");
      issue(SUB32, 64'h0000_0000_8000_0000, 64'h1, 16'h0, 5'd8, 5'd1, 64'h102C, "R6 sub32 min-1 trap");
      issue(SUBU32, 64'h0000_0000_8000_0000, 64'h1, 16'h0, 5'd9, 5'd1, 64'h1030, "R3 R8 subu32 sext");
      issue(ADDU32, 64'h0000_0000_7FFF_FFFF, 64'h1, 16'h0, 5'd9, 5'd1, 64'h1034, "R3 R8 addu32 sext negative");
      issue(ADDI64, 64'h10, 64'h9999, 16'hFFFF, 5'd10, 5'd11, 64'h1038, "R4 addi64 minus one to rt");
      issue(ADDI32, 64'h0000_0000_7FFF_FFF0, 64'h0, 16'h0010, 5'd10, 5'd12, 64'h103C, "R4 R5 addi32 trap");
      issue(ADDIU32, 64'h0000_0000_7FFF_FFF0, 64'h0, 16'h0010, 5'd10, 5'd12, 64'h1040, "R4 R8 addiu32 wraps");
      issue(ADD64, 64'h1, 64'h2, 16'h0, 5'd0, 5'd13, 64'h1044, "R9 dest zero discarded");
      issue(ADD64, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 16'h0, 5'd0, 5'd13, 64'h1048, "R9 dest zero still traps");
      issue(ADDI64, 64'h1, 64'h0, 16'h0001, 5'd14, 5'd0, 64'h104C, "R9 R4 imm dest rt zero");
      idle(3);
      issue(SUB64, 64'h8000_0000_0000_0000, 64'h1, 16'h0, 5'd1, 5'd1, 64'h2000, "R7 back-to-back trap a");
      issue(ADD32, 64'h7FFF_FFFF, 64'h7FFF_FFFF, 16'h0, 5'd1, 5'd1, 64'h2004, "R7 back-to-back trap b");
      issue(ADD64, 64'h3, 64'h4, 16'h0, 5'd1, 5'd1, 64'h2008, "R1 write after trap");
      idle(2);

      for (int i = 0; i < 300; i++) begin
         logic [3:0] op;
         op = 4'($urandom_range(0, 15));
         issue(op, pick(), pick(), 16'($urandom()), 5'($urandom()), 5'($urandom()),
               64'h4000 + 64'(i) * 4, "R1 R2 R3 R5 R6 random");
         if ($urandom_range(0, 5) == 0) idle(1);
      end
      idle(4);

      mon_en = 1'b0;
      if (sb_q.size() != 0) begin
         tests_run++;
         tests_failed++;
         $display("FAIL R1 scoreboard: act %0d pending exp 0", sb_q.size());
      end
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end
endmodule